// File: doc/BRIEF.md
# Periodic Sleep Wake-Up Controller

This block puts a radio modem's processor through timed sleep periods. When the processor raises its sleep request, the block waits until both serial request-to-send lines are quiet. It then times a fixed interval (50 ms in the intended system) as a count of system clock cycles. At the end of the interval it drops an active-low interrupt for one clock. If request-to-send activity on either port shows up during the interval, the interval is cut short and the interrupt is raised at once.

Each interrupt caused only by the timer counts one periodic wake. While that count stays below a programmable limit, the processor acknowledges the interrupt and the block starts the next interval by itself. A wake caused by port activity, or the wake that reaches the limit, asserts the radio enable and the line-driver enable together and clears the wake count. Both enables stay on until the next sleep request is accepted. A new rising edge of the sleep request restarts the interval at any time.

Top module: `slp_wake_ctl`

## Requirements
- R1: While reset is held, `nmi_n` is high and both enables are low.
- R2: With both RTS lines idle, the interrupt pulse follows the rising edge of `sleep_req` after `INTERVAL_CYC`+2 clock edges; that is, it is visible after the (`INTERVAL_CYC`+2)-th edge, counting the edge that samples the rise as the first.
- R3: `nmi_n` is low for exactly one clock per wake.
- R4: An RTS line (active high) that goes high during an interval ends it. The interrupt is visible after the third clock edge that samples the line high, and both enables assert in the same cycle.
- R5: A timer wake whose new count is still below the limit leaves both enables low. A `wake_ack` pulse then starts the next interval, whose interrupt follows the acknowledging edge by `INTERVAL_CYC`+2 edges.
- R6: The timer wake that brings the count to `wake_limit` asserts `radio_en` and `drv_en` together with its interrupt. After that wake is acknowledged, no further interrupt occurs.
- R7: A `wake_limit` of 0 or 1 makes every timer wake assert both enables.
- R8: A sleep request made while either RTS line is high is held off, and no interrupt occurs. The interval starts once both lines are low, and its interrupt comes `INTERVAL_CYC`+3 edges after the line is driven low.
- R9: Both enables fall on the edge that samples a rising `sleep_req` and otherwise stay high once set.
- R10: A new rising edge of `sleep_req` during an interval restarts it from zero.
- R11: The wake count is cleared by a port-activity wake and by a limit wake, and by nothing else. After either, a full `wake_limit` timer wakes are needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request from the processor; its rising edge is used |
| rts_a | input | 1 | Request-to-send of port A, active high, asynchronous |
| rts_b | input | 1 | Request-to-send of port B, active high, asynchronous |
| wake_limit | input | LIM_W | Number of timer wakes before full power-up |
| wake_ack | input | 1 | Processor acknowledge of a pending interrupt |
| nmi_n | output | 1 | Active-low one-clock wake interrupt |
| radio_en | output | 1 | Radio power enable |
| drv_en | output | 1 | Serial line-driver enable |

## Verification
The bench measures the exact distance from a sleep edge or acknowledge to the interrupt. An off-by-one in the timer, or a missed synchroniser stage on the RTS path, shows up as a shifted count. It injects RTS at random points in an interval to catch a design that ignores activity or waits for the full interval. It runs limit values of 0, 1 and above, and checks that the wake count persists across sessions but is cleared after a power-up. A design that never clears the count would power up early, and one that mishandles a zero limit would never power up. It also holds RTS high across a sleep request, so a design that starts timing anyway would raise an interrupt that should not occur.

// File: rtl/slp_wake_ctl.sv
module slp_wake_ctl #(
  parameter int INTERVAL_CYC = 500000,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             rts_a,
  input  logic             rts_b,
  input  logic [LIM_W-1:0] wake_limit,
  input  logic             wake_ack,
  output logic             nmi_n,
  output logic             radio_en,
  output logic             drv_en
);
  localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(INTERVAL_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_TIME, ST_ACK} st_t;

  st_t              st;
  logic [1:0]       rts_a_sy, rts_b_sy;
  logic             sleep_q;
  logic [TW-1:0]    tmr;
  logic [LIM_W-1:0] wake_cnt;
  logic             pwr;

  wire              rts_any    = rts_a_sy[1] | rts_b_sy[1];
  wire              sleep_rise = sleep_req & ~sleep_q;
  wire              fire       = (st == ST_TIME) & ((tmr == T_LAST) | rts_any) & ~sleep_rise;
  wire [LIM_W:0]    cnt_inc    = {1'b0, wake_cnt} + 1'b1;
  wire [LIM_W:0]    lim_eff    = (wake_limit == '0) ? (LIM_W+1)'(1) : {1'b0, wake_limit};
  wire              pwr_up     = rts_any | (cnt_inc >= lim_eff);

  assign radio_en = pwr;
  assign drv_en   = pwr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_a_sy <= '0;
      rts_b_sy <= '0;
    end else begin
      rts_a_sy <= {rts_a_sy[0], rts_a};
      rts_b_sy <= {rts_b_sy[0], rts_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sleep_q  <= 1'b0;
      tmr      <= '0;
      wake_cnt <= '0;
      nmi_n    <= 1'b1;
      pwr      <= 1'b0;
    end else begin
      sleep_q <= sleep_req;
      nmi_n   <= ~fire;
      if (sleep_rise) begin
        st  <= ST_HOLD;
        pwr <= 1'b0;
        tmr <= '0;
      end else begin
        case (st)
          ST_HOLD: begin
            tmr <= '0;
            if (!rts_any) st <= ST_TIME;
          end
          ST_TIME: begin
            if (fire) begin
              st <= ST_ACK;
              if (pwr_up) begin
                pwr      <= 1'b1;
                wake_cnt <= '0;
              end else begin
                wake_cnt <= cnt_inc[LIM_W-1:0];
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_ACK: begin
            if (wake_ack) st <= pwr ? ST_IDLE : ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module slp_wake_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic nmi_n,
  input logic radio_en,
  input logic drv_en
);
  assert_reset_outputs_R1: assert property (@(posedge clk)
    !rst_n |=> (nmi_n && !radio_en && !drv_en));

  assert_nmi_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |=> nmi_n);

  assert_enables_paired_R6: assert property (@(posedge clk) disable iff (!rst_n)
    radio_en == drv_en);

  assert_enable_with_nmi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(radio_en) |-> !nmi_n);

  assert_sleep_drops_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |=> !radio_en);

  assert_enable_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (radio_en && !$rose(sleep_req)) |=> radio_en);
endmodule

bind slp_wake_ctl slp_wake_ctl_chk u_chk (.*);

// File: tb/sim_slp_wake_ctl.sv
module sim_slp_wake_ctl;
  localparam int IV = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0, rts_a = 1'b0, rts_b = 1'b0, wake_ack = 1'b0;
  logic [7:0] wake_limit = 8'd3;
  logic       nmi_n, radio_en, drv_en;
  int         checks = 0, fails = 0, wcnt = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  slp_wake_ctl #(.INTERVAL_CYC(IV), .LIM_W(8)) u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_power(int cnt, int lim);
    return cnt >= ((lim < 2) ? 1 : lim);
  endfunction

  task automatic wait_nmi(input int inj_at, input bit use_b, output int n);
    n = 0;
    while (n < 500) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) begin sleep_req = 1'b0; wake_ack = 1'b0; end
      if (inj_at >= 0 && n == inj_at) begin
        if (use_b) rts_b = 1'b1; else rts_a = 1'b1;
      end
      if (!nmi_n) break;
    end
  endtask

  task automatic count_nmi(input int cyc, output int lows);
    lows = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      sleep_req = 1'b0; wake_ack = 1'b0;
      if (!nmi_n) lows++;
    end
  endtask

  task automatic idle(int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, lows;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 nmi_n", nmi_n, 1);
    chk("R1 radio_en", radio_en, 0);
    chk("R1 drv_en", drv_en, 0);
    rst_n = 1'b1;
    idle(4);

    wake_limit = 8'd3;
    sleep_req = 1'b1; wait_nmi(-1, 0, n);
    chk("R2 latency", n, IV + 2);
    chk("R5 en low on wake 1", radio_en, 0);
    @(negedge clk);
    chk("R3 pulse width", nmi_n, 1);
    wake_ack = 1'b1; wait_nmi(-1, 0, n);
    chk("R5 re-arm latency", n, IV + 2);
    chk("R5 en low on wake 2", radio_en, 0);
    wake_ack = 1'b1; wait_nmi(-1, 0, n);
    chk("R6 latency wake 3", n, IV + 2);
    chk("R6 radio_en", radio_en, 1);
    chk("R6 drv_en", drv_en, 1);
    wake_ack = 1'b1; count_nmi(IV + 10, lows);
    chk("R6 no further nmi", lows, 0);
    chk("R9 enable held", radio_en, 1);

    sleep_req = 1'b1; @(negedge clk);
    chk("R9 enable dropped", radio_en, 0);
    wait_nmi(-1, 0, n);
    chk("R2 latency after drop", n, IV + 1);
    chk("R11 wake 1 en low", radio_en, 0);
    wake_ack = 1'b1; wait_nmi(5, 0, n);
    chk("R4 early end", n, 8);
    chk("R4 radio_en", radio_en, 1);
    chk("R4 drv_en", drv_en, 1);
    rts_a = 1'b0; wake_ack = 1'b1; idle(4);

    sleep_req = 1'b1; wait_nmi(-1, 0, n);
    chk("R11 wake 1 en", radio_en, 0);
    wake_ack = 1'b1; wait_nmi(-1, 0, n);
    chk("R11 wake 2 en", radio_en, 0);
    wake_ack = 1'b1; wait_nmi(-1, 0, n);
    chk("R11 wake 3 en", radio_en, 1);
    wake_ack = 1'b1; idle(4);

    wake_limit = 8'd0;
    sleep_req = 1'b1; wait_nmi(-1, 0, n);
    chk("R7 limit0 latency", n, IV + 2);
    chk("R7 limit0 en", radio_en, 1);
    wake_ack = 1'b1; idle(4);
    wake_limit = 8'd1;
    sleep_req = 1'b1; wait_nmi(-1, 0, n);
    chk("R7 limit1 en", drv_en, 1);
    wake_ack = 1'b1; idle(4);

    wake_limit = 8'd3;
    sleep_req = 1'b1; count_nmi(8, lows);
    sleep_req = 1'b1; wait_nmi(-1, 0, n);
    chk("R10 restart latency", n, IV + 2);
    chk("R10 no early nmi", lows, 0);

    rts_b = 1'b1; idle(3);
    sleep_req = 1'b1; count_nmi(IV + 20, lows);
    chk("R8 held off", lows, 0);
    chk("R8 en low", radio_en, 0);
    rts_b = 1'b0; wait_nmi(-1, 0, n);
    chk("R8 start after release", n, IV + 3);
    wcnt = 2;

    for (int t = 0; t < 25; t++) begin
      int lim;
      idle(4);
      lim = int'($urandom % 5);
      wake_limit = 8'(lim);
      sleep_req = 1'b1;
      for (int k = 0; k < 8; k++) begin
        bit inj, pwr, use_b;
        int d;
        inj = ($urandom % 4) == 0;
        use_b = $urandom % 2;
        d = 1 + int'($urandom % (IV - 2));
        wait_nmi(inj ? d : -1, use_b, n);
        if (inj) begin
          chk("R4 random early end", n, d + 3);
          pwr = 1'b1; wcnt = 0;
        end else begin
          chk("R5 random latency", n, IV + 2);
          wcnt++;
          pwr = exp_power(wcnt, lim);
          if (pwr) wcnt = 0;
        end
        chk(inj ? "R4 random enable" : "R6 random enable", radio_en, int'(pwr));
        chk("R6 random driver", drv_en, int'(pwr));
        rts_a = 1'b0; rts_b = 1'b0;
        wake_ack = 1'b1;
        if (pwr) break;
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule